// File: doc/BRIEF.md
# Link Rate and Lane Selector

This block chooses the narrowest, slowest serial link set-up that can carry a requested video mode. It is given the maximum rate code and the lane-count capability byte read earlier from the attached sink, together with the pixel clock of the mode in kHz. It then walks a fixed ladder of link capacities, lowest first, and stops at the first rung that is strictly larger than the pixel clock. The result is a lane count (0, 1, 2 or 4), a per-lane link clock in kHz (162000 or 270000), and a flag telling whether the mode fits at all.

The search is started by a one-cycle strobe. It looks at one ladder entry per clock, so the answer takes one to six cycles. A one-cycle completion pulse marks the answer, and the answer stays on the outputs until the next search ends. Reading the capability bytes from the sink is done elsewhere; they reach this block as plain inputs.

Top module: `lrs_link_select`

## Requirements
- R1: After reset, laneCount, linkClkKhz, modeValid and done are all 0.
- R2: The capacity ladder is, by index 0 to 5: 54000, 90000, 108000, 180000, 216000 and 360000 kHz. Indices 0 and 1 mean 1 lane, 2 and 3 mean 2 lanes, 4 and 5 mean 4 lanes. The first examined entry whose capacity is strictly greater than pixelClkKhz is selected.
- R3: When rateCode is 8'h06, or any value other than 8'h0A, only the even indices 0, 2 and 4 are examined, so a selected link clock is always 162000.
- R4: When rateCode is 8'h0A, all six indices are examined in ascending order. An even selected index gives linkClkKhz 162000 and an odd one gives 270000.
- R5: The lane cap is laneCapByte[4:0]; bits 7:5 are ignored. With a cap of 1, examining an index above 1 ends the search with no selection. With a cap of 2, examining an index above 3 does the same. Any other cap value allows every entry.
- R6: When no entry is selected, laneCount and linkClkKhz are both 0.
- R7: modeValid is 1 exactly when the reported laneCount is not 0.
- R8: If start is sampled high at clock edge E0, done is high for exactly one cycle, following edge Ek. Here k is the number of entries examined, counting the one that ended the search. The results change together with that pulse.
- R9: The results are held until the next done pulse. A start that arrives while a search is in progress is ignored.
- R10: rateCode, laneCapByte and pixelClkKhz are captured on the accepted start edge. Later changes to them do not affect that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (accepted only when idle) |
| rateCode | input | 8 | Sink maximum link rate code |
| laneCapByte | input | 8 | Sink lane-count capability byte |
| pixelClkKhz | input | PIX_W (32) | Requested pixel clock in kHz |
| laneCount | output | LANE_STEPS (3) | Selected lane count: 0, 1, 2 or 4 |
| linkClkKhz | output | PIX_W (32) | Selected link clock in kHz, or 0 |
| modeValid | output | 1 | The mode fits in the sink's capability |
| done | output | 1 | One-cycle pulse marking new results |

## Verification
A wrong scan index, or a wrong step for the rate, shows up in the same done pulse. It appears as a wrong lane count or link clock, or as done arriving after the wrong number of cycles, which is at most six cycles after start. A wrong captured cap or pixel clock can be seen once the inputs are changed during a scan, because the result then follows the new values. A control state that never leaves the scan shows as a missing done pulse. A state that re-arms itself shows as a second pulse, or as results that move while the block is idle.

// File: rtl/lrs_pkg.sv
`timescale 1ns/1ps
package lrs_pkg;
  localparam logic [7:0] RATE_CODE_SLOW = 8'h06;
  localparam logic [7:0] RATE_CODE_FAST = 8'h0A;

  typedef enum logic {ST_IDLE, ST_SCAN} lrs_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic finish;
  } lrs_ctrl_t;

  // per-cycle verdict on the entry under examination
  typedef struct packed {
    logic hit;
    logic capStop;
    logic lastEntry;
  } lrs_stat_t;
endpackage

// File: rtl/lrs_ctrl.sv
`timescale 1ns/1ps
module lrs_ctrl
  import lrs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  lrs_stat_t stat,
  output lrs_ctrl_t strobes
);
  lrs_state_t stateQ, stateD;

  always_comb begin
    strobes = '0;
    stateD  = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobes.load = 1'b1;
          stateD       = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (stat.hit || stat.capStop || stat.lastEntry) begin
          strobes.finish = 1'b1;
          stateD         = ST_IDLE;
        end else begin
          strobes.advance = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  // R9: a start during a scan must not reload the search
  p_busy_no_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_SCAN) |-> !strobes.load);

  // R8: finishing always returns control to idle
  p_finish_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.finish |=> (stateQ == ST_IDLE));
endmodule

// File: rtl/lrs_datapath.sv
`timescale 1ns/1ps
module lrs_datapath
  import lrs_pkg::*;
#(
  parameter int PIX_W         = 32,
  parameter int LANE_STEPS    = 3,
  parameter int CAP_FIELD_W   = 5,
  parameter int BASE_SLOW_KHZ = 54000,
  parameter int BASE_FAST_KHZ = 90000,
  parameter int LINK_SLOW_KHZ = 162000,
  parameter int LINK_FAST_KHZ = 270000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  lrs_ctrl_t             strobes,
  input  logic [7:0]            rateCode,
  input  logic [7:0]            laneCapByte,
  input  logic [PIX_W-1:0]      pixelClkKhz,
  output lrs_stat_t             stat,
  output logic [LANE_STEPS-1:0] laneCount,
  output logic [PIX_W-1:0]      linkClkKhz,
  output logic                  modeValid,
  output logic                  done
);
  localparam int NUM_ENTRIES = 2 * LANE_STEPS;
  localparam int IDX_W       = $clog2(NUM_ENTRIES);
  localparam int MAX_LANES   = 1 << (LANE_STEPS - 1);
  localparam logic [7:0] CAP_MASK = 8'((1 << CAP_FIELD_W) - 1);

  // capacity ladder, interleaved by rate, computed per entry
  logic [PIX_W-1:0] capTab [NUM_ENTRIES];
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cap
    localparam int BASE = (g % 2) ? BASE_FAST_KHZ : BASE_SLOW_KHZ;
    assign capTab[g] = PIX_W'(BASE * (1 << (g / 2)));
  end

  logic [IDX_W-1:0]      idxQ;
  logic                  fastQ;
  logic [7:0]            capQ;
  logic [PIX_W-1:0]      pixQ;
  logic [LANE_STEPS-1:0] lanesQ;
  logic [PIX_W-1:0]      linkQ;
  logic                  validQ;
  logic                  doneQ;

  logic [LANE_STEPS-1:0] curLanes;
  logic                  capLimited;
  logic [IDX_W-1:0]      stepSize;

  always_comb begin
    curLanes   = LANE_STEPS'(1) << (idxQ >> 1);
    capLimited = (capQ != 8'd0) && ((capQ & (capQ - 8'd1)) == 8'd0) &&
                 (int'(capQ) < MAX_LANES);
    stat.capStop   = capLimited && (int'(curLanes) > int'(capQ));
    stat.hit       = capTab[idxQ] > pixQ;
    stat.lastEntry = fastQ ? (idxQ == IDX_W'(NUM_ENTRIES - 1))
                           : (idxQ == IDX_W'(NUM_ENTRIES - 2));
    stepSize   = fastQ ? IDX_W'(1) : IDX_W'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idxQ   <= '0;
      fastQ  <= 1'b0;
      capQ   <= '0;
      pixQ   <= '0;
      lanesQ <= '0;
      linkQ  <= '0;
      validQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strobes.finish;
      if (strobes.load) begin
        idxQ  <= '0;
        fastQ <= (rateCode == RATE_CODE_FAST);
        capQ  <= laneCapByte & CAP_MASK;
        pixQ  <= pixelClkKhz;
      end else if (strobes.advance) begin
        idxQ <= idxQ + stepSize;
      end
      if (strobes.finish) begin
        if (stat.hit && !stat.capStop) begin
          lanesQ <= curLanes;
          linkQ  <= idxQ[0] ? PIX_W'(LINK_FAST_KHZ) : PIX_W'(LINK_SLOW_KHZ);
          validQ <= 1'b1;
        end else begin
          lanesQ <= '0;
          linkQ  <= '0;
          validQ <= 1'b0;
        end
      end
    end
  end

  assign laneCount  = lanesQ;
  assign linkClkKhz = linkQ;
  assign modeValid  = validQ;
  assign done       = doneQ;

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: results only move with a finish
  p_hold_results_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.finish |=> ($stable(laneCount) && $stable(linkClkKhz) && $stable(modeValid)));

  // R10: captured inputs stay put during a scan
  p_capture_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.load |=> ($stable(pixQ) && $stable(capQ) && $stable(fastQ)));

  // R7: valid tracks a nonzero lane count
  p_valid_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    modeValid == (laneCount != '0));

  // R2 and R6: lane count is a legal value, paired with a legal clock
  p_lanes_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(laneCount));
  p_zero_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (laneCount == '0) |-> (linkClkKhz == '0));

  // R3: a slow sink never receives the fast link clock
  p_slow_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fastQ) |-> (linkClkKhz != PIX_W'(LINK_FAST_KHZ)));

  // R5: a selection never exceeds a limiting lane cap
  p_cap_respected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && capLimited) |-> (int'(laneCount) <= int'(capQ)));
endmodule

// File: rtl/lrs_link_select.sv
`timescale 1ns/1ps
module lrs_link_select
  import lrs_pkg::*;
#(
  parameter int PIX_W      = 32,
  parameter int LANE_STEPS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [7:0]            rateCode,
  input  logic [7:0]            laneCapByte,
  input  logic [PIX_W-1:0]      pixelClkKhz,
  output logic [LANE_STEPS-1:0] laneCount,
  output logic [PIX_W-1:0]      linkClkKhz,
  output logic                  modeValid,
  output logic                  done
);
  lrs_ctrl_t strobes;
  lrs_stat_t stat;

  lrs_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .stat    (stat),
    .strobes (strobes)
  );

  lrs_datapath #(
    .PIX_W      (PIX_W),
    .LANE_STEPS (LANE_STEPS)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .rateCode    (rateCode),
    .laneCapByte (laneCapByte),
    .pixelClkKhz (pixelClkKhz),
    .stat        (stat),
    .laneCount   (laneCount),
    .linkClkKhz  (linkClkKhz),
    .modeValid   (modeValid),
    .done        (done)
  );
endmodule

// File: tb/lrs_link_select_tb.sv
`timescale 1ns/1ps
module lrs_link_select_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  rateCode = 8'h00;
  logic [7:0]  laneCapByte = 8'h00;
  logic [31:0] pixelClkKhz = '0;
  logic [2:0]  laneCount;
  logic [31:0] linkClkKhz;
  logic        modeValid;
  logic        done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lrs_link_select dut_i (
    .clk (clk), .rst_n (rst_n), .start (start), .rateCode (rateCode),
    .laneCapByte (laneCapByte), .pixelClkKhz (pixelClkKhz),
    .laneCount (laneCount), .linkClkKhz (linkClkKhz),
    .modeValid (modeValid), .done (done)
  );

  typedef struct packed {
    logic [7:0]  rate;
    logic [7:0]  cap;
    logic [31:0] pix;
    logic [2:0]  lanes;
    logic [31:0] lclk;
    logic [3:0]  cyc;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{8'h06, 8'h04, 32'd50000,  3'd1, 32'd162000, 4'd1},  // R2 R3
    '{8'h06, 8'h04, 32'd60000,  3'd2, 32'd162000, 4'd2},  // R3
    '{8'h06, 8'h04, 32'd200000, 3'd4, 32'd162000, 4'd3},  // R3
    '{8'h06, 8'h04, 32'd216000, 3'd0, 32'd0,      4'd3},  // R6 strict
    '{8'h0A, 8'h04, 32'd60000,  3'd1, 32'd270000, 4'd2},  // R4
    '{8'h0A, 8'h04, 32'd100000, 3'd2, 32'd162000, 4'd3},  // R4
    '{8'h0A, 8'h04, 32'd200000, 3'd4, 32'd162000, 4'd5},  // R4
    '{8'h0A, 8'h04, 32'd300000, 3'd4, 32'd270000, 4'd6},  // R4
    '{8'h0A, 8'h04, 32'd360000, 3'd0, 32'd0,      4'd6},  // R6
    '{8'h0A, 8'h01, 32'd100000, 3'd0, 32'd0,      4'd3},  // R5 cap 1
    '{8'h0A, 8'h02, 32'd150000, 3'd2, 32'd270000, 4'd4},  // R5 cap 2
    '{8'h0A, 8'h02, 32'd200000, 3'd0, 32'd0,      4'd5},  // R5 cap 2
    '{8'h06, 8'h01, 32'd50000,  3'd1, 32'd162000, 4'd1},  // R5
    '{8'h06, 8'h01, 32'd60000,  3'd0, 32'd0,      4'd2},  // R5
    '{8'h14, 8'h04, 32'd100000, 3'd2, 32'd162000, 4'd2},  // R3 unknown code
    '{8'h0A, 8'h84, 32'd300000, 3'd4, 32'd270000, 4'd6},  // R5 high bits
    '{8'h0A, 8'hE1, 32'd50000,  3'd1, 32'd162000, 4'd1},  // R5 high bits
    '{8'h0A, 8'h03, 32'd300000, 3'd4, 32'd270000, 4'd6},  // R5 odd cap
    '{8'h0A, 8'h00, 32'd0,      3'd1, 32'd162000, 4'd1}   // R5 zero cap
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // pulse start at the next edge, return cycles until done (0 on timeout)
  task automatic run_search(input logic [7:0] r, input logic [7:0] c,
                            input logic [31:0] p, output int cyc);
    @(negedge clk);
    rateCode = r; laneCapByte = c; pixelClkKhz = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (done) begin cyc = n; break; end
    end
  endtask

  task automatic check_result(input string req, input logic [2:0] el,
                              input logic [31:0] ec);
    chk(laneCount == el, req, "laneCount", laneCount, el);
    chk(linkClkKhz == ec, req, "linkClkKhz", linkClkKhz, ec);
    chk(modeValid == (el != 0), "R7", "modeValid", modeValid, el != 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(laneCount == 0, "R1", "laneCount", laneCount, 0);
    chk(linkClkKhz == 0, "R1", "linkClkKhz", linkClkKhz, 0);
    chk(modeValid == 0, "R1", "modeValid", modeValid, 0);
    chk(done == 0, "R1", "done", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // vector table: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      run_search(VEC[i].rate, VEC[i].cap, VEC[i].pix, cyc);
      chk(cyc == int'(VEC[i].cyc), "R8", "latency", cyc, VEC[i].cyc);
      check_result("R2", VEC[i].lanes, VEC[i].lclk);
      @(negedge clk);
      chk(done == 0, "R8", "done pulse width", done, 0);
    end

    // R9: results held while idle, even with new inputs and no start
    run_search(8'h0A, 8'h04, 32'd300000, cyc);
    rateCode = 8'h06; laneCapByte = 8'h01; pixelClkKhz = 32'd0;
    repeat (8) @(negedge clk);
    chk(done == 0, "R9", "done while idle", done, 0);
    check_result("R9", 3'd4, 32'd270000);

    // R9: start during a scan is ignored
    @(negedge clk);
    rateCode = 8'h0A; laneCapByte = 8'h04; pixelClkKhz = 32'd300000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rateCode = 8'h06; laneCapByte = 8'h01; pixelClkKhz = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 2;
    for (int n = 3; n <= 20; n++) begin
      @(negedge clk);
      if (done) begin cyc = n; break; end
    end
    chk(cyc == 6, "R9", "latency with busy start", cyc, 6);
    check_result("R9", 3'd4, 32'd270000);
    repeat (3) @(negedge clk);
    chk(done == 0, "R9", "no second search", done, 0);

    // R10: inputs changed right after capture have no effect
    @(negedge clk);
    rateCode = 8'h0A; laneCapByte = 8'h02; pixelClkKhz = 32'd150000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rateCode = 8'h06; laneCapByte = 8'h04; pixelClkKhz = 32'd10;
    cyc = 0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (done) begin cyc = n; break; end
    end
    chk(cyc == 4, "R10", "latency", cyc, 4);
    check_result("R10", 3'd2, 32'd270000);

    // R1: reset mid-result clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check_result("R1", 3'd0, 32'd0);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule